// File: doc/BRIEF.md
# Dual-Chain Hash Accumulator and Finaliser

This block sits between a message source and a bit-serial mixing core. It keeps two chaining registers: a 96-bit main chain with its own pointer and a 64-bit final chain with its own pointer. Each accepted message bit is XORed with the main-chain bit at the pointer. The result goes to the core, and the core's answer is written back into the same position. A one-request, one-acknowledge port carries every step to the core, so a core of any latency can be attached.

An end command starts a fixed finalisation. First, 32 steps stir the main chain alone. Next, 64 steps copy each main-chain result into the final chain as well. A snapshot of the core's visible state and of the ten generator counters is then folded bit by bit into the final chain. Finally, 64 steps stir the final chain alone. After that the 160-bit digest is read out one bit per read strobe: first the main chain from its pointer onward, then the final chain from its pointer onward. A sticky flag marks a message longer than the counters can represent.

Top module: `hash_chain_ctrl`

## Requirements
- R1: After reset the main chain holds the parameter `IV` (chain bit i equals IV bit i), and the final chain is all zero. Both chain pointers and the read index are 0. `msg_ready` is 1, and `dig_ready`, `core_req` and `len_err` are 0.
- R2: An accepted message bit m sends `m ^ C[Y]` to the core. The core result is written to `C[Y]`, and Y then advances modulo 96.
- R3: `core_req` stays high with `core_in` stable from issue until the cycle in which `core_ack` is high, and that cycle completes the step. At most one step is outstanding. `core_req` is low in the cycle after an acknowledge.
- R4: `msg_ready` is high only in the message phase with no step outstanding. `msg_valid` has no effect at any other time.
- R5: `end_req` is taken only in the message phase with no step outstanding and `msg_valid` low. At any other time it has no effect. Once taken, 32 steps each send `C[Y]` alone, write the result to `C[Y]` and advance Y.
- R6: Next, 64 steps each send `C[Y]`, write the result to both `C[Y]` and `F[Z]`, and advance Y and Z (Z modulo 64).
- R7: The core state inputs are sampled in the first cycle after the last R6 step. Final-chain steps then send `b ^ F[Z]`, write the result to `F[Z]` and advance Z. The bits b are taken in this order: `core_s`, `core_r`, `core_dflag` (only when the sampled `core_r` is 1), `core_d` LSB first, then each of the ten 4-bit fields of `core_t` (field i at bits 4i+3:4i) in turn, LSB first.
- R8: After the R7 bits, for each generator g from 0 to 9, `gen_k[32g+31:32g] - 6` (modulo 2^32) is sent as 32 final-chain steps, LSB first.
- R9: Finalisation ends with 64 steps that send `F[Z]` alone and write the result back to `F[Z]`. No further core requests follow.
- R10: Once finalisation is done, `dig_ready` is high while fewer than 160 reads have been made. Read number W (starting at 0) shows `C[(Y+W) mod 96]` for W < 96 and `F[(Z+W-96) mod 64]` otherwise. A high `rd_en` advances W, and `dig_ready` falls after 160 reads.
- R11: Before finalisation is done, `rd_en` has no effect and the read sequence later starts at W = 0. `dig_bit` is stable while no read is made.
- R12: `len_err` rises when a message bit is accepted after `MAX_MSG_BITS` bits have already been accepted, and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| msg_valid | input | 1 | Message bit offered |
| msg_bit | input | 1 | Message bit value |
| msg_ready | output | 1 | Message bit can be taken |
| end_req | input | 1 | End-of-message command |
| rd_en | input | 1 | Digest read strobe |
| dig_ready | output | 1 | Digest bit available |
| dig_bit | output | 1 | Current digest bit |
| len_err | output | 1 | Sticky message-length error |
| core_req | output | 1 | Step request to the mixing core |
| core_in | output | 1 | Step input bit to the core |
| core_ack | input | 1 | Core completes the step |
| core_out | input | 1 | Core result bit, valid with core_ack |
| core_s | input | 1 | Core state bit folded first |
| core_r | input | 1 | Core state bit that also gates the flag bit |
| core_dflag | input | 1 | Core flag bit, folded only when core_r is 1 |
| core_d | input | 4 | Core selector value |
| core_t | input | 40 | Ten 4-bit core table entries |
| gen_k | input | 320 | Ten 32-bit generator step counters |

## Verification
On every cycle, the assertions check the request hold and the gap after an acknowledge, the advance of the main pointer on message steps, and that an end command is ignored while a step is outstanding. They also check that reads before completion leave the read index unchanged, that the digest bit is stable between reads, that the read index stays bounded and that the length flag is sticky. The ordering and content of the finalisation can only be shown by the bench's scenarios, which compare every core request against a behavioural model of both chains. These scenarios cover the conditional flag bit with both values of the sampled bit, counter values that wrap when 6 is subtracted, and the digest read order. They also check the length overflow, and that message, end and read inputs offered during finalisation leave no trace.

// File: rtl/hash_chain_ctrl.sv
module hash_chain_ctrl #(
  parameter longint unsigned MAX_MSG_BITS = 64'h1_0000_0000,
  parameter logic [95:0]     IV           = 96'h6E92_9774_29C3_42E3_2756_E9D8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         msg_valid,
  input  logic         msg_bit,
  output logic         msg_ready,
  input  logic         end_req,
  input  logic         rd_en,
  output logic         dig_ready,
  output logic         dig_bit,
  output logic         len_err,
  output logic         core_req,
  output logic         core_in,
  input  logic         core_ack,
  input  logic         core_out,
  input  logic         core_s,
  input  logic         core_r,
  input  logic         core_dflag,
  input  logic [3:0]   core_d,
  input  logic [39:0]  core_t,
  input  logic [319:0] gen_k
);
  localparam int CL = 96;
  localparam int FL = 64;
  localparam int NG = 10;
  localparam int KW = 32;
  localparam int DL = CL + FL;
  localparam int KB = 7 + 4 * NG;
  localparam int SW = KB + KW * NG;

  typedef enum logic [2:0] {PH_MSG, PH_CHN, PH_MIX, PH_SNAP, PH_FOLD, PH_DONE} phase_t;

  phase_t        ph;
  logic [CL-1:0] c;
  logic [FL-1:0] f;
  logic [6:0]    y;
  logic [5:0]    z;
  logic [7:0]    w;
  logic [8:0]    cnt, cnt_last, cnt_nx;
  logic          busy, op_in, snap_ld;
  logic [SW-1:0] snap_q, snap_vec;
  logic [32:0]   msg_cnt;
  logic [6:0]    y_nx;
  logic [7:0]    ysum, cidx;
  logic [5:0]    fidx;

  always_comb begin
    snap_vec = '0;
    snap_vec[6:0] = {core_d, core_dflag, core_r, core_s};
    snap_vec[KB-1:7] = core_t;
    for (int g = 0; g < NG; g++)
      snap_vec[KB + KW*g +: KW] = gen_k[KW*g +: KW] - KW'(6);
  end

  always_comb begin
    case (ph)
      PH_CHN:  cnt_last = 9'd31;
      PH_MIX:  cnt_last = 9'd63;
      PH_SNAP: cnt_last = 9'(SW - 1);
      default: cnt_last = 9'd63;
    endcase
  end

  assign cnt_nx    = (ph == PH_SNAP && cnt == 9'd1 && !snap_q[1]) ? 9'd3 : cnt + 9'd1;
  assign y_nx      = (y == 7'(CL - 1)) ? 7'd0 : y + 7'd1;
  assign ysum      = {1'b0, y} + w;
  assign cidx      = (ysum >= 8'(CL)) ? ysum - 8'(CL) : ysum;
  assign fidx      = z + w[5:0] + 6'd32;
  assign dig_bit   = (w < 8'(CL)) ? c[cidx[6:0]] : f[fidx];
  assign dig_ready = (ph == PH_DONE) && (w < 8'(DL));
  assign msg_ready = (ph == PH_MSG) && !busy;
  assign core_req  = busy;
  assign core_in   = op_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_MSG;  c <= IV;  f <= '0;  y <= '0;  z <= '0;  w <= '0;
      cnt <= '0;  busy <= 1'b0;  op_in <= 1'b0;  snap_ld <= 1'b0;
      snap_q <= '0;  msg_cnt <= '0;  len_err <= 1'b0;
    end else if (!busy) begin
      case (ph)
        PH_MSG: begin
          if (msg_valid) begin
            busy  <= 1'b1;
            op_in <= msg_bit ^ c[y];
            if (!len_err) begin
              if (msg_cnt == MAX_MSG_BITS[32:0]) len_err <= 1'b1;
              else msg_cnt <= msg_cnt + 33'd1;
            end
          end else if (end_req) begin
            ph <= PH_CHN;  cnt <= '0;
          end
        end
        PH_CHN, PH_MIX: begin busy <= 1'b1; op_in <= c[y]; end
        PH_SNAP: begin
          if (snap_ld) begin snap_q <= snap_vec; snap_ld <= 1'b0; end
          else begin busy <= 1'b1; op_in <= snap_q[cnt] ^ f[z]; end
        end
        PH_FOLD: begin busy <= 1'b1; op_in <= f[z]; end
        PH_DONE: if (rd_en && w < 8'(DL)) w <= w + 8'd1;
        default: ;
      endcase
    end else if (core_ack) begin
      busy <= 1'b0;
      case (ph)
        PH_MSG, PH_CHN: begin c[y] <= core_out; y <= y_nx; end
        PH_MIX: begin c[y] <= core_out; f[z] <= core_out; y <= y_nx; z <= z + 6'd1; end
        default: begin f[z] <= core_out; z <= z + 6'd1; end
      endcase
      if (ph != PH_MSG) begin
        if (cnt == cnt_last) begin
          cnt <= '0;
          case (ph)
            PH_CHN:  ph <= PH_MIX;
            PH_MIX:  begin ph <= PH_SNAP; snap_ld <= 1'b1; end
            PH_SNAP: ph <= PH_FOLD;
            default: ph <= PH_DONE;
          endcase
        end else cnt <= cnt_nx;
      end
    end
  end

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    core_req && !core_ack |=> core_req && $stable(core_in));
  assert_req_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    core_req && core_ack |=> !core_req);
  assert_ptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    core_req && core_ack && ph == PH_MSG |=>
      y == (($past(y) == 7'(CL - 1)) ? 7'd0 : $past(y) + 7'd1));
  assert_end_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    end_req && busy && ph == PH_MSG |=> ph == PH_MSG);
  assert_early_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && ph != PH_DONE |=> $stable(w));
  assert_dig_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dig_ready && !rd_en |=> $stable(dig_bit));
  assert_read_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    w <= 8'(DL));
  assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |=> len_err);
endmodule

// File: tb/test_hash_chain_ctrl.sv
module test_hash_chain_ctrl;
  localparam logic [95:0] IVB = 96'h6E92_9774_29C3_42E3_2756_E9D8;
  localparam int MAXB = 40;

  logic clk = 0, rst_n = 0;
  logic msg_valid = 0, msg_bit = 0, end_req = 0, rd_en = 0;
  logic core_ack = 0, core_out = 0;
  logic core_s = 1, core_r = 1, core_dflag = 1;
  logic [3:0] core_d = 4'hA;
  logic [39:0] core_t;
  logic [319:0] gen_k;
  logic msg_ready, dig_ready, dig_bit, len_err, core_req, core_in;

  int tests = 0, fails = 0, mcount = 0, opn = 0;
  bit cm[96]; bit fm[64]; int ym, zm;
  int kindq[$]; bit valq[$];
  logic [15:0] lf = 16'hACE1;
  bit ended = 0;

  always #10 clk = ~clk;

  hash_chain_ctrl #(.MAX_MSG_BITS(MAXB)) i_hash_chain_ctrl (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_bit(msg_bit),
    .msg_ready(msg_ready), .end_req(end_req), .rd_en(rd_en),
    .dig_ready(dig_ready), .dig_bit(dig_bit), .len_err(len_err),
    .core_req(core_req), .core_in(core_in), .core_ack(core_ack),
    .core_out(core_out), .core_s(core_s), .core_r(core_r),
    .core_dflag(core_dflag), .core_d(core_d), .core_t(core_t), .gen_k(gen_k));

  task automatic check(string tag, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic finish_tb();
    if (!ended) begin
      ended = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // behavioural core and reference model, one check per step
  initial begin
    forever begin
      @(negedge clk);
      core_ack = 0;
      if (core_req && rst_n) begin
        int k; bit v, e, o; string tag;
        repeat (opn % 3) @(negedge clk);
        opn++;
        if (kindq.size() == 0) begin
          check("R9 unexpected core request", 1'b1, 1'b0);
        end else begin
          k = kindq.pop_front(); v = valq.pop_front();
          case (k)
            0: begin e = v ^ cm[ym]; tag = "R2 message step"; end
            1: begin e = cm[ym]; tag = "R5 chain step"; end
            2: begin e = cm[ym]; tag = "R6 copy step"; end
            3: begin e = v ^ fm[zm]; tag = "R7/R8 snapshot step"; end
            default: begin e = fm[zm]; tag = "R9 fold step"; end
          endcase
          check(tag, core_in, e);
          lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
          o = e ^ lf[5];
          if (k <= 2) begin cm[ym] = o; ym = (ym + 1) % 96; end
          if (k >= 2) begin fm[zm] = o; zm = (zm + 1) % 64; end
          core_out = o; core_ack = 1;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    finish_tb();
  end

  task automatic do_reset();
    rst_n = 0; msg_valid = 0; end_req = 0; rd_en = 0;
    kindq.delete(); valq.delete();
    for (int i = 0; i < 96; i++) cm[i] = IVB[i];
    for (int i = 0; i < 64; i++) fm[i] = 0;
    ym = 0; zm = 0; mcount = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 msg_ready after reset", msg_ready, 1'b1);
    check("R1 dig_ready after reset", dig_ready, 1'b0);
    check("R1 core_req after reset", core_req, 1'b0);
    check("R1 len_err after reset", len_err, 1'b0);
  endtask

  task automatic send_bit(bit b);
    @(negedge clk);
    while (!msg_ready) @(negedge clk);
    msg_valid = 1; msg_bit = b;
    @(posedge clk);
    kindq.push_back(0); valq.push_back(b); mcount++;
    #1 msg_valid = 0;
  endtask

  task automatic push_fin(int k, bit v);
    kindq.push_back(k); valq.push_back(v);
  endtask

  task automatic do_end();
    logic [31:0] kv;
    @(negedge clk);
    while (!msg_ready) @(negedge clk);
    end_req = 1;
    for (int i = 0; i < 32; i++) push_fin(1, 0);
    for (int i = 0; i < 64; i++) push_fin(2, 0);
    push_fin(3, core_s);
    push_fin(3, core_r);
    if (core_r) push_fin(3, core_dflag);
    for (int i = 0; i < 4; i++) push_fin(3, core_d[i]);
    for (int t = 0; t < 10; t++)
      for (int i = 0; i < 4; i++) push_fin(3, core_t[4*t + i]);
    for (int g = 0; g < 10; g++) begin
      kv = gen_k[32*g +: 32] - 32'd6;
      for (int i = 0; i < 32; i++) push_fin(3, kv[i]);
    end
    for (int i = 0; i < 64; i++) push_fin(4, 0);
    @(posedge clk);
    #1 end_req = 0;
  endtask

  task automatic run(bit rv, int nbits);
    core_r = rv;
    do_reset();
    for (int i = 0; i < nbits; i++) send_bit(1'((i * 7 + nbits) % 3 == 0));
    check("R12 length flag", len_err, 1'(mcount > MAXB));
    do_end();
    // offered during finalisation: must leave no trace
    @(negedge clk);
    msg_valid = 1; msg_bit = 1; end_req = 1; rd_en = 1;
    repeat (40) @(negedge clk);
    check("R4 msg_ready during finalisation", msg_ready, 1'b0);
    check("R11 dig_ready during finalisation", dig_ready, 1'b0);
    msg_valid = 0; end_req = 0; rd_en = 0;
    while (!dig_ready) @(negedge clk);
    tests++;
    if (kindq.size() != 0) begin
      fails++;
      $display("FAIL R9 steps left actual=%0d expected=0", kindq.size());
    end
    repeat (3) @(negedge clk);
    check("R9 no request after done", core_req, 1'b0);
    for (int wv = 0; wv < 160; wv++) begin
      bit e;
      e = (wv < 96) ? cm[(ym + wv) % 96] : fm[(zm + wv - 96) % 64];
      check("R10 digest ready", dig_ready, 1'b1);
      check("R10 digest bit", dig_bit, e);
      if (wv == 0) begin
        @(negedge clk);
        check("R11 digest bit stable", dig_bit, e);
      end
      rd_en = 1;
      @(posedge clk);
      #1 rd_en = 0;
      @(negedge clk);
    end
    check("R10 ready low after 160 reads", dig_ready, 1'b0);
    check("R12 length flag kept", len_err, 1'(mcount > MAXB));
  endtask

  initial begin
    for (int i = 0; i < 10; i++) core_t[4*i +: 4] = 4'((i * 3 + 1) % 16);
    for (int g = 0; g < 10; g++)
      gen_k[32*g +: 32] = (g == 3) ? 32'd3 : 32'(6 + 12345 * g + 7);
    run(1'b1, 20);
    run(1'b0, 41);
    core_s = 0; core_dflag = 0; core_d = 4'h5;
    run(1'b1, 0);
    finish_tb();
  end
endmodule